// File: doc/BRIEF.md
# Transmit Descriptor Fetcher

This engine moves outgoing frames from host memory onto a byte stream. Software builds a ring of 16-byte descriptors in memory. Each descriptor names a buffer and its length and carries a flag that says whether the hardware may use it. Software gives the engine the ring base and pulses a kick strobe. From that point the engine fetches descriptors one after another through a single-word memory port. For each descriptor that hardware owns, it reads the buffer and sends its bytes out in address order. It then writes the first descriptor word back with the ownership flag cleared, which returns the descriptor to software.

The ring length is never programmed. A descriptor that carries the end-of-ring flag sends the next fetch back to the ring base. A descriptor still owned by software parks the engine at that slot. The next kick makes it read that same slot again. Each returned descriptor produces a one-cycle done pulse.

Top module: `tx_desc_fetch`

## Requirements
- R1: After reset, `mem_req`, `tx_valid` and `desc_done` are low and stay low until the first `kick` pulse.
- R2: The descriptor at ring index i starts at `ring_base + 16*i`. It is read as four little-endian 32-bit words at offsets 0, 4, 8 and 12. In the control word at offset 0, bit 31 is ownership (1 = hardware), bit 30 is end-of-ring and bits 12:0 are the byte length. The word at offset 4 is ignored. The buffer address is the word at offset 8 plus 2^32 times the word at offset 12, cut to the address width. Every memory address the engine issues has its two low bits at zero.
- R3: When the fetched control word has bit 31 clear, the engine issues no further memory request, stream beat or done pulse. The next `kick` makes it read the same descriptor address again.
- R4: The engine sends exactly `length` bytes, starting at the buffer address and going up one address per byte. The byte at address a is bits 8*(a mod 4)+7 : 8*(a mod 4) of the memory word at a with its low two bits cleared. `tx_last` is high only on the final byte. No beat is offered while a memory request is pending.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold steady.
- R6: After the final byte is accepted, the engine writes the control word back to the descriptor's offset 0 with bit 31 cleared and all other bits unchanged. `desc_done` is high for exactly the one cycle after that write is accepted.
- R7: A descriptor with length 0 produces no stream beat and is still written back as in R6.
- R8: After a descriptor with bit 30 set is written back, the next fetch starts at `ring_base`. After any other descriptor it starts at the next 16-byte slot.
- R9: A memory request holds its address and direction until `mem_ready` is high. A read completes on `mem_rvalid`, and no new request is issued while a read is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | ADDR_W | Byte address of ring slot 0 |
| kick | input | 1 | Start strobe, honoured when idle |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the buffer |
| tx_ready | input | 1 | Stream sink ready |
| desc_done | output | 1 | One-cycle pulse per returned descriptor |

## Verification
The hardest case to reach from the ports is a descriptor still owned by software sitting in the middle of a ring. The engine must park there and then pick up at exactly that slot after a later kick, without skipping ahead or wrapping. The bench builds rings with one slot left unowned and checks the address of the last fetch and a long quiet window. It then hands the slot over, kicks again, and follows the walk through the end-of-ring wrap until the engine parks on slot 0, which the engine has itself returned. Sweeps also cover buffer lengths 0 to 10 at every start lane, two ring bases, and both free-running and randomly throttled memory and stream handshakes.

// File: rtl/tdf_pkg.sv
package tdf_pkg;
   localparam int DWORD_W    = 32;
   localparam int LANES      = DWORD_W / 8;
   localparam int DESC_BYTES = 16;
   localparam int DESC_SHIFT = $clog2(DESC_BYTES);

   typedef enum logic [2:0] {
      S_IDLE,
      S_DREQ,
      S_DWAIT,
      S_DECODE,
      S_BREQ,
      S_BWAIT,
      S_EMIT,
      S_WREQ
   } tdf_state_e;
endpackage

// File: rtl/tdf_ring_index.sv
module tdf_ring_index import tdf_pkg::*; #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic              advance,
   input  logic              wrap,
   output logic [ADDR_W-1:0] desc_addr
);
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (advance) begin
         idx_q <= wrap ? '0 : idx_q + 1'b1;
      end
   end

   assign desc_addr = ring_base + (ADDR_W'(idx_q) << DESC_SHIFT);
endmodule

// File: rtl/tdf_byte_pick.sv
module tdf_byte_pick import tdf_pkg::*; (
   input  logic [DWORD_W-1:0]       word,
   input  logic [$clog2(LANES)-1:0] sel,
   output logic [7:0]               byte_out
);
   logic [7:0] lane_b [LANES];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_b[i] = word[8*i +: 8];
   end

   assign byte_out = lane_b[sel];
endmodule

// File: rtl/tdf_buf_cursor.sv
module tdf_buf_cursor import tdf_pkg::*; #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [LEN_W-1:0]  length,
   input  logic              step,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              is_last,
   output logic              word_end
);
   localparam int LANE_W = $clog2(LANES);

   logic [LEN_W-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr <= '0;
         remain_q <= '0;
      end else if (load) begin
         cur_addr <= start_addr;
         remain_q <= length;
      end else if (step) begin
         cur_addr <= cur_addr + 1'b1;
         remain_q <= remain_q - 1'b1;
      end
   end

   assign is_last  = (remain_q == LEN_W'(1));
   assign word_end = &cur_addr[LANE_W-1:0];
endmodule

// File: rtl/tx_desc_fetch.sv
module tx_desc_fetch import tdf_pkg::*; #(
   parameter int ADDR_W  = 32,
   parameter int IDX_W   = 12,
   parameter int LEN_W   = 13,
   parameter int OWN_BIT = 31,
   parameter int EOR_BIT = 30
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  ring_base,
   input  logic               kick,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [DWORD_W-1:0] mem_wdata,
   input  logic               mem_ready,
   input  logic [DWORD_W-1:0] mem_rdata,
   input  logic               mem_rvalid,
   output logic               tx_valid,
   output logic [7:0]         tx_data,
   output logic               tx_last,
   input  logic               tx_ready,
   output logic               desc_done
);
   localparam int LO_W   = (ADDR_W > DWORD_W) ? DWORD_W : ADDR_W;
   localparam int LANE_W = $clog2(LANES);

   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_aw
      $error("tx_desc_fetch: ADDR_W must lie in 8..64");
   end
   if (OWN_BIT > 31 || EOR_BIT >= OWN_BIT || LEN_W > EOR_BIT || LEN_W < 1) begin : g_bad_fields
      $error("tx_desc_fetch: control word fields overlap or exceed 32 bits");
   end
   if (IDX_W + DESC_SHIFT > ADDR_W) begin : g_bad_idx
      $error("tx_desc_fetch: ring index does not fit the address width");
   end

   tdf_state_e        state_q;
   logic [1:0]        wcnt_q;
   logic [31:0]       ctrl_q;
   logic [LO_W-1:0]   lo_q;
   logic [31:0]       word_q;
   logic              done_q;
   logic [ADDR_W-1:0] buf_addr;
   logic [ADDR_W-1:0] desc_addr;
   logic [ADDR_W-1:0] cur_addr;
   logic              is_last;
   logic              word_end;
   logic [7:0]        pick_b;
   logic              advance;
   logic              load;
   logic              step;
   logic              rd_beat;

   assign rd_beat = (state_q == S_DWAIT) && mem_rvalid;
   assign advance = (state_q == S_WREQ) && mem_ready;
   assign load    = (state_q == S_DECODE);
   assign step    = (state_q == S_EMIT) && tx_ready;

   if (ADDR_W > DWORD_W) begin : g_wide
      logic [ADDR_W-DWORD_W-1:0] hi_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hi_q <= '0;
         end else if (rd_beat && wcnt_q == 2'd3) begin
            hi_q <= mem_rdata[ADDR_W-DWORD_W-1:0];
         end
      end
      assign buf_addr = {hi_q, lo_q};
   end else begin : g_narrow
      assign buf_addr = lo_q;
   end

   tdf_ring_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .ring_base (ring_base),
      .advance   (advance),
      .wrap      (ctrl_q[EOR_BIT]),
      .desc_addr (desc_addr)
   );

   tdf_buf_cursor #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cursor (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .start_addr (buf_addr),
      .length     (ctrl_q[LEN_W-1:0]),
      .step       (step),
      .cur_addr   (cur_addr),
      .is_last    (is_last),
      .word_end   (word_end)
   );

   tdf_byte_pick u_pick (
      .word     (word_q),
      .sel      (cur_addr[LANE_W-1:0]),
      .byte_out (pick_b)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         wcnt_q  <= '0;
         ctrl_q  <= '0;
         lo_q    <= '0;
         word_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (kick) begin
                  wcnt_q  <= '0;
                  state_q <= S_DREQ;
               end
            end
            S_DREQ: begin
               if (mem_ready) state_q <= S_DWAIT;
            end
            S_DWAIT: begin
               if (mem_rvalid) begin
                  unique case (wcnt_q)
                     2'd0: begin
                        ctrl_q  <= mem_rdata;
                        wcnt_q  <= 2'd1;
                        state_q <= mem_rdata[OWN_BIT] ? S_DREQ : S_IDLE;
                     end
                     2'd1: begin
                        wcnt_q  <= 2'd2;
                        state_q <= S_DREQ;
                     end
                     2'd2: begin
                        lo_q    <= mem_rdata[LO_W-1:0];
                        wcnt_q  <= 2'd3;
                        state_q <= S_DREQ;
                     end
                     default: begin
                        state_q <= S_DECODE;
                     end
                  endcase
               end
            end
            S_DECODE: begin
               state_q <= (ctrl_q[LEN_W-1:0] == '0) ? S_WREQ : S_BREQ;
            end
            S_BREQ: begin
               if (mem_ready) state_q <= S_BWAIT;
            end
            S_BWAIT: begin
               if (mem_rvalid) begin
                  word_q  <= mem_rdata;
                  state_q <= S_EMIT;
               end
            end
            S_EMIT: begin
               if (tx_ready) begin
                  if (is_last)       state_q <= S_WREQ;
                  else if (word_end) state_q <= S_BREQ;
               end
            end
            S_WREQ: begin
               if (mem_ready) begin
                  done_q  <= 1'b1;
                  wcnt_q  <= '0;
                  state_q <= S_DREQ;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = (state_q == S_DREQ) || (state_q == S_BREQ) || (state_q == S_WREQ);
      mem_we    = (state_q == S_WREQ);
      mem_wdata = ctrl_q & ~(32'd1 << OWN_BIT);
      unique case (state_q)
         S_DREQ:  mem_addr = desc_addr + ADDR_W'({wcnt_q, 2'b00});
         S_BREQ:  mem_addr = {cur_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
         default: mem_addr = desc_addr;
      endcase
   end

   assign tx_valid  = (state_q == S_EMIT);
   assign tx_data   = pick_b;
   assign tx_last   = (state_q == S_EMIT) && is_last;
   assign desc_done = done_q;
endmodule

// File: rtl/tdf_checker.sv
module tdf_checker #(
   parameter int ADDR_W  = 32,
   parameter int OWN_BIT = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [31:0]       mem_wdata,
   input logic              mem_ready,
   input logic              mem_rvalid,
   input logic              tx_valid,
   input logic [7:0]        tx_data,
   input logic              tx_last,
   input logic              tx_ready,
   input logic              desc_done
);
   logic rd_out_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                                  rd_out_q <= 1'b0;
      else if (mem_req && !mem_we && mem_ready)    rd_out_q <= 1'b1;
      else if (mem_rvalid)                         rd_out_q <= 1'b0;
   end

   // R9: request held until accepted
   a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   // R9: one read outstanding
   a_r9_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_out_q |-> !mem_req);

   // R2: word-aligned addresses
   a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00);

   // R5: stream holds under backpressure
   a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

   // R6: writeback clears ownership
   a_r6_wb_own_clear: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> !mem_wdata[OWN_BIT]);

   // R6: done follows an accepted write
   a_r6_done_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
      desc_done |-> $past(mem_req && mem_we && mem_ready));

   // R4: no beat while memory is busy
   a_r4_no_beat_during_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !tx_valid);
endmodule

bind tx_desc_fetch tdf_checker #(.ADDR_W(ADDR_W), .OWN_BIT(OWN_BIT)) u_tdf_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_ready  (mem_ready),
   .mem_rvalid (mem_rvalid),
   .tx_valid   (tx_valid),
   .tx_data    (tx_data),
   .tx_last    (tx_last),
   .tx_ready   (tx_ready),
   .desc_done  (desc_done)
);

// File: tb/tb_tx_desc_fetch.sv
module tb_tx_desc_fetch;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ring_base = 32'h100;
   logic          kick = 1'b0;
   logic          mem_req, mem_we, mem_ready, mem_rvalid;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata, mem_rdata;
   logic          tx_valid, tx_last, tx_ready, desc_done;
   logic [7:0]    tx_data;

   always #2 clk = ~clk;

   tx_desc_fetch dut (
      .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .kick(kick),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
      .desc_done(desc_done)
   );

   int vecs = 0;
   int errs = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory model with host write port
   logic [31:0] mem [0:4095];
   logic [15:0] lfsr = 16'hACE1;
   bit          thr = 1'b0;
   logic        rdy_bit = 1'b1;
   logic        rsp_pend = 1'b0;
   logic [1:0]  rsp_dly = '0;
   logic [31:0] rsp_data = '0;
   logic        h_we = 1'b0;
   logic [AW-1:0] h_addr = '0;
   logic [31:0] h_data = '0;

   assign mem_ready = rdy_bit && !rsp_pend;

   initial begin
      mem_rvalid = 1'b0;
      mem_rdata  = '0;
      tx_ready   = 1'b1;
   end

   always @(posedge clk) begin
      lfsr       <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy_bit    <= thr ? (lfsr[0] | lfsr[3]) : 1'b1;
      tx_ready   <= thr ? (lfsr[5] | lfsr[8]) : 1'b1;
      mem_rvalid <= 1'b0;
      if (h_we) mem[h_addr[13:2]] <= h_data;
      if (mem_req && mem_ready) begin
         if (mem_we) begin
            mem[mem_addr[13:2]] <= mem_wdata;
         end else begin
            rsp_pend <= 1'b1;
            rsp_dly  <= thr ? lfsr[2:1] : 2'd0;
            rsp_data <= mem[mem_addr[13:2]];
         end
      end
      if (rsp_pend) begin
         if (rsp_dly == 2'd0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= rsp_data;
            rsp_pend   <= 1'b0;
         end else begin
            rsp_dly <= rsp_dly - 1'b1;
         end
      end
   end

   task automatic host_wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      h_we = 1'b1; h_addr = a; h_data = d;
      @(negedge clk);
      h_we = 1'b0;
   endtask

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 13) + (a >> 7));
   endfunction

   // expectations
   logic [8:0]  exp_b [$];
   logic [31:0] exp_wa [$];
   logic [31:0] exp_wd [$];
   bit          exp_z [$];
   int done_cnt = 0;
   int last_cnt = 0;
   int nz_cnt = 0;
   int idle_cyc = 0;
   logic [AW-1:0] last_rd = '0;
   logic wr_acc_d = 1'b0;
   logic hold_p = 1'b0;
   logic [8:0] hold_v = '0;
   logic mreq_p = 1'b0;
   logic [AW:0] mreq_v = '0;

   // port monitors
   always @(posedge clk) begin
      if (rst_n) begin
         if (tx_valid && tx_ready) begin
            if (exp_b.size() == 0) chk(1'b0, "R4 unexpected beat", {tx_last, tx_data}, 0);
            else begin
               logic [8:0] e;
               e = exp_b.pop_front();
               chk({tx_last, tx_data} == e, "R4 stream byte/last", {tx_last, tx_data}, e);
            end
            if (tx_last) last_cnt++;
         end
         if (hold_p) chk(tx_valid && {tx_last, tx_data} == hold_v, "R5 hold", {tx_valid, tx_last, tx_data}, {1'b1, hold_v});
         if (mreq_p) chk(mem_req && {mem_we, mem_addr} == mreq_v, "R9 request hold", {mem_req, mem_we, mem_addr}, {1'b1, mreq_v});
         chk(desc_done == wr_acc_d, "R6 done timing", desc_done, wr_acc_d);
         if (desc_done) done_cnt++;
         if (mem_req && mem_we && mem_ready) begin
            if (exp_wa.size() == 0) chk(1'b0, "R6 unexpected write", mem_addr, 0);
            else begin
               logic [31:0] ea, ed;
               bit z;
               ea = exp_wa.pop_front(); ed = exp_wd.pop_front(); z = exp_z.pop_front();
               chk(mem_addr == ea, z ? "R7 writeback address" : "R6 writeback address", mem_addr, ea);
               chk(mem_wdata == ed, z ? "R7 writeback data" : "R6 writeback data", mem_wdata, ed);
            end
         end
         if (mem_req && !mem_we && mem_ready) last_rd <= mem_addr;
         idle_cyc <= mem_req ? 0 : idle_cyc + 1;
      end
      wr_acc_d <= rst_n && mem_req && mem_we && mem_ready;
      hold_p   <= rst_n && tx_valid && !tx_ready;
      hold_v   <= {tx_last, tx_data};
      mreq_p   <= rst_n && mem_req && !mem_ready;
      mreq_v   <= {mem_we, mem_addr};
   end

   task automatic do_kick();
      @(negedge clk); kick = 1'b1;
      @(negedge clk); kick = 1'b0;
   endtask

   task automatic build(input logic [AW-1:0] base, input int n, input int b, input int gap,
                        output logic [31:0] gap_ctrl);
      gap_ctrl = '0;
      for (int i = 0; i < n; i++) begin
         int len, off, ba;
         logic [31:0] c;
         len = (b * 6 + i) % 11;
         off = (b + i) % 4;
         ba  = 32'h1000 + i * 64 + off;
         c   = {1'b1, (i == n - 1), 17'((b * 5 + i) * 2749), 13'(len)};
         if (i == gap) begin gap_ctrl = c; c[31] = 1'b0; end
         host_wr(base + 16 * i, c);
         host_wr(base + 16 * i + 4, 32'hDEAD0000 | i);
         host_wr(base + 16 * i + 8, ba);
         host_wr(base + 16 * i + 12, 32'h0);
         for (int k = 0; k < len; k++) exp_b.push_back({k == len - 1, pat(ba + k)});
         if (len != 0) nz_cnt++;
         exp_wa.push_back(base + 16 * i);
         exp_wd.push_back({1'b0, c[30:0]});
         exp_z.push_back(len == 0);
      end
   endtask

   task automatic settle();
      repeat (50) @(negedge clk);
   endtask

   int target = 0;

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin : main
      logic [31:0] gc;
      for (int w = 32'h400; w < 32'h800; w++) mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
      for (int w = 0; w < 32'h400; w++) mem[w] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         chk(!mem_req && !tx_valid && !desc_done, "R1 reset idle", {mem_req, tx_valid, desc_done}, 0);
      end

      // sweep lengths 0..10, all lanes, two bases, two throttle modes
      for (int b = 0; b < 8; b++) begin
         thr = b[0];
         ring_base = b[1] ? 32'h400 : 32'h100;
         build(ring_base, 6, b, -1, gc);
         target += 6;
         do_kick();
         wait (done_cnt == target);
         settle();
         chk(last_rd == ring_base, "R8 wrap to base after end-of-ring", last_rd, ring_base);
         chk(idle_cyc >= 40, "R3 parked on returned slot", idle_cyc, 40);
         chk(exp_b.size() == 0, "R4 all bytes sent", exp_b.size(), 0);
         chk(exp_wa.size() == 0, "R6 all written back", exp_wa.size(), 0);
      end

      // re-kick with nothing owned: rereads slot 0 and stays quiet
      do_kick();
      settle();
      chk(last_rd == ring_base, "R3 reread same slot", last_rd, ring_base);
      chk(done_cnt == target, "R3 no done when unowned", done_cnt, target);
      chk(idle_cyc >= 40, "R3 no request after unowned", idle_cyc, 40);

      // software-owned slot in the middle of the ring
      thr = 1'b1;
      ring_base = 32'h100;
      build(ring_base, 4, 9, 2, gc);
      do_kick();
      wait (done_cnt == target + 2);
      settle();
      chk(done_cnt == target + 2, "R3 stop at unowned slot", done_cnt, target + 2);
      chk(last_rd == ring_base + 32, "R3 parked address", last_rd, ring_base + 32);
      chk(idle_cyc >= 40, "R3 quiet while parked", idle_cyc, 40);
      host_wr(ring_base + 32, gc);
      do_kick();
      wait (done_cnt == target + 4);
      settle();
      target += 4;
      chk(done_cnt == target, "R3 resume count", done_cnt, target);
      chk(last_rd == ring_base, "R8 wrap after resume", last_rd, ring_base);
      chk(exp_b.size() == 0 && exp_wa.size() == 0, "R6 resume drained", exp_b.size() + exp_wa.size(), 0);
      chk(mem[ring_base[13:2] + 8] == {1'b0, gc[30:0]}, "R6 resumed slot returned", mem[ring_base[13:2] + 8], {1'b0, gc[30:0]});
      chk(last_cnt == nz_cnt, "R7 zero-length sends no beat", last_cnt, nz_cnt);

      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule